// File: doc/BRIEF.md
# Printable-String Sweep Generator

This block feeds a bank of parallel hash workers with candidate passwords. It walks every string of printable characters (codes 32 to 126), starting with a single space and working up to eight tildes. Each cycle it hands one distinct candidate to every attached worker. A candidate is packed into a 64-bit word, with its first character in the low byte. The candidate's length and a per-worker valid strobe travel with the word.

The enumeration behaves like an odometer. The front character (byte 0) changes fastest. When every active character has wrapped, the string grows by one character and every position restarts at the lowest code. Workers report a match by raising their hit line and returning the candidate that produced it. The first accepted hit freezes the generator and latches that candidate as the result. If the space runs out first, an exhausted flag rises instead. Hits still in flight are accepted after exhaustion until one lands.

Top module: `pwd_sweep`

## Requirements
- R1: While reset is high and after it ends, no candidate is valid, and done, exhausted, result_word and result_len are all zero until a start arrives.
- R2: In the cycle after start is sampled, worker slot 0 carries the first candidate: length 1, word 0x20.
- R3: In every valid candidate, each of the first `len` bytes lies between CHAR_LO and CHAR_HI, and every higher byte is zero.
- R4: The step from one candidate to the next increments byte 0. A byte at CHAR_HI wraps to CHAR_LO and carries into the next byte up.
- R5: A carry out of the highest active byte increases the length by one, and all active bytes then hold CHAR_LO. For example, "~" is followed by two spaces, and "~~" is followed by three spaces.
- R6: Within one cycle, slot k+1 holds the successor of slot k. Slot 0 of the next cycle holds the successor of the last slot of the previous cycle. The valid mask is always a run of ones from slot 0.
- R7: A hit sampled on a clock edge makes done high from the next cycle. From that cycle all valids are low, and result_word/result_len hold the word and length reported by the lowest-indexed hitting worker.
- R8: While done is high and no start arrives, further hits are ignored and the result stays unchanged.
- R9: The slots past the last candidate of the space are not valid. Exhausted rises in the cycle after the last candidate is issued, and the valids are then low. A hit arriving after exhaustion is still accepted as in R7.
- R10: Hits before the first start are ignored. A start while done is high restarts the sweep from the first candidate and clears done and exhausted.
- R11: The worker count, maximum length and character range are parameters. Defaults: 2 workers, length 8, codes 32 to 126.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart the sweep |
| hit | input | NUM_WORKERS | Per-worker match flag |
| hit_word | input | NUM_WORKERS*64 | Candidate that matched, per worker |
| hit_len | input | NUM_WORKERS*4 | Length of the matched candidate, per worker |
| cand_valid | output | NUM_WORKERS | Per-worker candidate strobe |
| cand_word | output | NUM_WORKERS*64 | Packed candidate, byte 0 is the front character |
| cand_len | output | NUM_WORKERS*4 | Candidate length |
| done | output | 1 | A match has been accepted |
| exhausted | output | 1 | Every candidate has been issued |
| result_word | output | 64 | Matched candidate |
| result_len | output | 4 | Matched candidate length |

## Verification
Candidates appear in the cycle after the start edge and then advance on every edge. Done, the result and exhausted all settle one edge after the hit or after the last issue. The bench drives inputs just after a rising edge and samples on the falling edge that follows the edge where a result is due. A scoreboard queue holds the expected stream, computed from a candidate index with a mixed-radix conversion. The monitor pops one entry for each valid slot on each falling edge, so any slip in ordering or timing shows up as a mismatch.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    localparam int SLOT_CHARS = 8;
    localparam int CHAR_W     = 8;
    localparam int WORD_W     = SLOT_CHARS * CHAR_W;
    localparam int LEN_W      = $clog2(SLOT_CHARS + 1);

    typedef struct packed {
        logic [LEN_W-1:0]                  len;
        logic [SLOT_CHARS-1:0][CHAR_W-1:0] ch;
    } cand_t;

    function automatic cand_t first_cand(input int lo);
        cand_t c;
        c       = '0;
        c.len   = LEN_W'(1);
        c.ch[0] = CHAR_W'(lo);
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cand_to_word(input cand_t c);
        return c.ch;
    endfunction

    function automatic logic chars_in_range(input cand_t c, input int lo, input int hi);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < SLOT_CHARS; i++) begin
            if (i < int'(c.len)) begin
                if (int'(c.ch[i]) < lo || int'(c.ch[i]) > hi) ok = 1'b0;
            end else if (c.ch[i] != '0) begin
                ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/sweep_step.sv
module sweep_step
    import sweep_pkg::*;
#(
    parameter int MAX_LEN = 8,
    parameter int CHAR_LO = 32,
    parameter int CHAR_HI = 126
) (
    input  cand_t cur,
    output cand_t nxt,
    output logic  over
);
    localparam logic [CHAR_W-1:0] LO_C = CHAR_W'(CHAR_LO);
    localparam logic [CHAR_W-1:0] HI_C = CHAR_W'(CHAR_HI);

    logic carry;

    always_comb begin
        nxt   = cur;
        carry = 1'b1;
        over  = 1'b0;
        for (int i = 0; i < SLOT_CHARS; i++) begin
            if (carry && (i < int'(cur.len))) begin
                if (cur.ch[i] == HI_C) begin
                    nxt.ch[i] = LO_C;
                end else begin
                    nxt.ch[i] = cur.ch[i] + CHAR_W'(1);
                    carry     = 1'b0;
                end
            end
        end
        if (carry) begin
            if (int'(cur.len) >= MAX_LEN) begin
                over = 1'b1;
            end else begin
                nxt.len = cur.len + LEN_W'(1);
                for (int i = 0; i < SLOT_CHARS; i++) begin
                    if (i == int'(cur.len)) nxt.ch[i] = LO_C;
                end
            end
        end
    end

endmodule

// File: rtl/sweep_hit_pick.sv
module sweep_hit_pick
    import sweep_pkg::*;
#(
    parameter int NUM_WORKERS = 2
) (
    input  logic [NUM_WORKERS-1:0]        hit,
    input  logic [NUM_WORKERS*WORD_W-1:0] hit_word,
    input  logic [NUM_WORKERS*LEN_W-1:0]  hit_len,
    output logic                          any_hit,
    output logic [WORD_W-1:0]             sel_word,
    output logic [LEN_W-1:0]              sel_len
);
    always_comb begin
        any_hit  = 1'b0;
        sel_word = '0;
        sel_len  = '0;
        for (int k = NUM_WORKERS - 1; k >= 0; k--) begin
            if (hit[k]) begin
                any_hit  = 1'b1;
                sel_word = hit_word[k*WORD_W +: WORD_W];
                sel_len  = hit_len[k*LEN_W +: LEN_W];
            end
        end
    end

endmodule

// File: rtl/pwd_sweep.sv
module pwd_sweep
    import sweep_pkg::*;
#(
    parameter int NUM_WORKERS = 2,
    parameter int MAX_LEN     = 8,
    parameter int CHAR_LO     = 32,
    parameter int CHAR_HI     = 126
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [NUM_WORKERS-1:0]        hit,
    input  logic [NUM_WORKERS*WORD_W-1:0] hit_word,
    input  logic [NUM_WORKERS*LEN_W-1:0]  hit_len,
    output logic [NUM_WORKERS-1:0]        cand_valid,
    output logic [NUM_WORKERS*WORD_W-1:0] cand_word,
    output logic [NUM_WORKERS*LEN_W-1:0]  cand_len,
    output logic                          done,
    output logic                          exhausted,
    output logic [WORD_W-1:0]             result_word,
    output logic [LEN_W-1:0]              result_len
);
    localparam logic [NUM_WORKERS-1:0] ONE_W   = NUM_WORKERS'(1);
    localparam cand_t                  FIRST_C = first_cand(CHAR_LO);

    cand_t                base_q;
    logic                 running_q;
    logic                 armed_q;
    cand_t                slot   [NUM_WORKERS+1];
    logic [NUM_WORKERS:0] slot_ok;
    logic [NUM_WORKERS-1:0] step_over;

    logic                 any_hit;
    logic [WORD_W-1:0]    pick_word;
    logic [LEN_W-1:0]     pick_len;

    assign slot[0]    = base_q;
    assign slot_ok[0] = 1'b1;

    for (genvar k = 0; k < NUM_WORKERS; k++) begin : g_chain
        sweep_step #(
            .MAX_LEN (MAX_LEN),
            .CHAR_LO (CHAR_LO),
            .CHAR_HI (CHAR_HI)
        ) u_step (
            .cur  (slot[k]),
            .nxt  (slot[k+1]),
            .over (step_over[k])
        );
        assign slot_ok[k+1] = slot_ok[k] & ~step_over[k];

        assign cand_valid[k]                  = running_q & slot_ok[k];
        assign cand_word[k*WORD_W +: WORD_W]  = cand_to_word(slot[k]);
        assign cand_len[k*LEN_W +: LEN_W]     = slot[k].len;

        // R3
        char_range_chk: assert property (@(posedge clk) disable iff (rst)
            cand_valid[k] |-> chars_in_range(slot[k], CHAR_LO, CHAR_HI));

        // R5
        len_bound_chk: assert property (@(posedge clk) disable iff (rst)
            cand_valid[k] |-> (int'(cand_len[k*LEN_W +: LEN_W]) >= 1 &&
                               int'(cand_len[k*LEN_W +: LEN_W]) <= MAX_LEN));
    end

    sweep_hit_pick #(
        .NUM_WORKERS (NUM_WORKERS)
    ) u_pick (
        .hit      (hit),
        .hit_word (hit_word),
        .hit_len  (hit_len),
        .any_hit  (any_hit),
        .sel_word (pick_word),
        .sel_len  (pick_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= FIRST_C;
            running_q   <= 1'b0;
            armed_q     <= 1'b0;
            done        <= 1'b0;
            exhausted   <= 1'b0;
            result_word <= '0;
            result_len  <= '0;
        end else if (start) begin
            base_q      <= FIRST_C;
            running_q   <= 1'b1;
            armed_q     <= 1'b1;
            done        <= 1'b0;
            exhausted   <= 1'b0;
        end else if (armed_q && any_hit) begin
            running_q   <= 1'b0;
            armed_q     <= 1'b0;
            done        <= 1'b1;
            result_word <= pick_word;
            result_len  <= pick_len;
        end else if (running_q) begin
            if (!slot_ok[NUM_WORKERS]) begin
                running_q <= 1'b0;
                exhausted <= 1'b1;
            end else begin
                base_q    <= slot[NUM_WORKERS];
            end
        end
    end

    // R7
    quiet_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> cand_valid == '0);

    // R6
    valid_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (cand_valid & (cand_valid + ONE_W)) == '0);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(result_word) && $stable(result_len)));

    // R9
    quiet_when_exhausted_chk: assert property (@(posedge clk) disable iff (rst)
        exhausted |-> cand_valid == '0);

    // R2
    first_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        $past(start && !rst) |-> (cand_valid[0] && int'(cand_len[LEN_W-1:0]) == 1 &&
                                  cand_word[WORD_W-1:0] == WORD_W'(CHAR_LO)));

endmodule

// File: tb/pwd_sweep_bench.sv
module pwd_sweep_bench;
    import sweep_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 2;
    localparam int NB = 4;
    localparam int LB = 3;
    localparam int LOB = 32;
    localparam int HIB = 34;

    typedef struct {
        logic [63:0] w;
        logic [3:0]  l;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;

    // instance A: default parameters
    logic              st_a = 1'b0;
    logic [NA-1:0]     h_a  = '0;
    logic [NA*64-1:0]  hw_a = '0;
    logic [NA*4-1:0]   hl_a = '0;
    logic [NA-1:0]     v_a;
    logic [NA*64-1:0]  cw_a;
    logic [NA*4-1:0]   cl_a;
    logic              dn_a, ex_a;
    logic [63:0]       rw_a;
    logic [3:0]        rl_a;

    pwd_sweep u_pwd_sweep (
        .clk(clk), .rst(rst), .start(st_a), .hit(h_a), .hit_word(hw_a), .hit_len(hl_a),
        .cand_valid(v_a), .cand_word(cw_a), .cand_len(cl_a), .done(dn_a),
        .exhausted(ex_a), .result_word(rw_a), .result_len(rl_a));

    // instance B: small space for exhaustion
    logic              st_b = 1'b0;
    logic [NB-1:0]     h_b  = '0;
    logic [NB*64-1:0]  hw_b = '0;
    logic [NB*4-1:0]   hl_b = '0;
    logic [NB-1:0]     v_b;
    logic [NB*64-1:0]  cw_b;
    logic [NB*4-1:0]   cl_b;
    logic              dn_b, ex_b;
    logic [63:0]       rw_b;
    logic [3:0]        rl_b;

    pwd_sweep #(.NUM_WORKERS(NB), .MAX_LEN(LB), .CHAR_LO(LOB), .CHAR_HI(HIB)) u_pwd_sweep_small (
        .clk(clk), .rst(rst), .start(st_b), .hit(h_b), .hit_word(hw_b), .hit_len(hl_b),
        .cand_valid(v_b), .cand_word(cw_b), .cand_len(cl_b), .done(dn_b),
        .exhausted(ex_b), .result_word(rw_b), .result_len(rl_b));

    exp_t q_a[$];
    exp_t q_b[$];
    bit   mon_a = 1'b0;
    bit   mon_b = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // candidate index -> expected word, length and requirement tag
    function automatic exp_t model(input longint idx, input int lo, input int hi);
        exp_t   e;
        longint r    = longint'(hi - lo + 1);
        longint span = r;
        longint v    = idx;
        longint off;
        int     len  = 1;
        while (v >= span) begin
            v    -= span;
            span *= r;
            len++;
        end
        off  = v;
        e.w  = '0;
        for (int j = 0; j < len; j++) begin
            e.w[j*8 +: 8] = 8'(longint'(lo) + (v % r));
            v = v / r;
        end
        e.l = 4'(len);
        if (idx == 0)                 e.tag = "R2";
        else if (off == 0)            e.tag = "R5";
        else if ((off % r) == 0)      e.tag = "R4";
        else                          e.tag = "R6";
        return e;
    endfunction

    task automatic push_a(input longint from, input longint count);
        for (longint i = from; i < from + count; i++) q_a.push_back(model(i, 32, 126));
    endtask

    task automatic push_b(input longint from, input longint count);
        exp_t e;
        for (longint i = from; i < from + count; i++) begin
            e = model(i, LOB, HIB);
            e.tag = {"R11/", e.tag};
            q_b.push_back(e);
        end
    endtask

    function automatic bit range_ok(input logic [63:0] w, input logic [3:0] l,
                                    input int lo, input int hi);
        bit ok = 1'b1;
        for (int j = 0; j < 8; j++) begin
            if (j < int'(l)) begin
                if (int'(w[j*8 +: 8]) < lo || int'(w[j*8 +: 8]) > hi) ok = 1'b0;
            end else if (w[j*8 +: 8] != 8'h00) ok = 1'b0;
        end
        return ok;
    endfunction

    // monitors: one popped entry per valid slot, in slot order
    always @(negedge clk) begin
        exp_t e;
        if (mon_a) begin
            for (int k = 0; k < NA; k++) begin
                if (v_a[k]) begin
                    if (q_a.size() == 0) begin
                        chk(1'b0, "R6", "unexpected candidate", cw_a[k*64 +: 64], '0);
                    end else begin
                        e = q_a.pop_front();
                        chk(cw_a[k*64 +: 64] == e.w, e.tag, "word", cw_a[k*64 +: 64], e.w);
                        chk(cl_a[k*4 +: 4] == e.l, e.tag, "len", 64'(cl_a[k*4 +: 4]), 64'(e.l));
                        chk(range_ok(cw_a[k*64 +: 64], cl_a[k*4 +: 4], 32, 126), "R3",
                            "char range", cw_a[k*64 +: 64], e.w);
                    end
                end
            end
        end
        if (mon_b) begin
            for (int k = 0; k < NB; k++) begin
                if (v_b[k]) begin
                    if (q_b.size() == 0) begin
                        chk(1'b0, "R9", "candidate past end", cw_b[k*64 +: 64], '0);
                    end else begin
                        e = q_b.pop_front();
                        chk(cw_b[k*64 +: 64] == e.w, e.tag, "word", cw_b[k*64 +: 64], e.w);
                        chk(cl_b[k*4 +: 4] == e.l, e.tag, "len", 64'(cl_b[k*4 +: 4]), 64'(e.l));
                    end
                end
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic drain_a;
        do begin
            @(negedge clk);
            #1;
        end while (q_a.size() != 0);
    endtask

    task automatic drain_b;
        do begin
            @(negedge clk);
            #1;
        end while (q_b.size() != 0);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", 64'(tests), '0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(v_a == '0 && v_b == '0, "R1", "valids after reset", 64'({v_b, v_a}), '0);
        chk(!dn_a && !ex_a && !dn_b && !ex_b, "R1", "flags after reset",
            64'({dn_a, ex_a, dn_b, ex_b}), '0);
        chk(rw_a == '0 && rl_a == '0, "R1", "result after reset", rw_a, '0);

        // R10: hit before any start is ignored
        tick();
        h_b = 4'b0001; hw_b[63:0] = 64'h2121; hl_b[3:0] = 4'd2;
        tick();
        h_b = '0;
        @(negedge clk);
        chk(!dn_b, "R10", "hit before start", 64'(dn_b), 64'd0);
        chk(rw_b == '0, "R10", "result before start", rw_b, '0);

        // main stream: lengths 1, 2 and into 3
        push_a(0, 9300);
        mon_a = 1'b1;
        st_a = 1'b1; tick(); st_a = 1'b0;
        @(negedge clk);
        chk(!dn_a && !ex_a, "R2", "flags after start", 64'({dn_a, ex_a}), '0);
        drain_a();
        mon_a = 1'b0;

        // R7: both workers hit together, worker 0 wins
        tick();
        h_a = 2'b11;
        hw_a = {64'h0000_0000_0074_7365, 64'h0000_0000_0061_6263};
        hl_a = {4'd3, 4'd3};
        tick();
        h_a = '0;
        @(negedge clk);
        chk(dn_a, "R7", "done after hit", 64'(dn_a), 64'd1);
        chk(rw_a == 64'h0000_0000_0061_6263, "R7", "lowest worker word", rw_a, 64'h616263);
        chk(rl_a == 4'd3, "R7", "result len", 64'(rl_a), 64'd3);
        chk(v_a == '0, "R7", "valids after done", 64'(v_a), '0);

        // R8: later hits ignored
        tick();
        h_a = 2'b10; hw_a[127:64] = 64'h7a7a; hl_a[7:4] = 4'd2;
        tick();
        h_a = '0;
        repeat (2) @(negedge clk);
        chk(rw_a == 64'h0000_0000_0061_6263, "R8", "result held", rw_a, 64'h616263);
        chk(dn_a && v_a == '0, "R8", "still done", 64'({dn_a, v_a}), 64'h4);

        // R10: restart from the first candidate
        push_a(0, 6);
        mon_a = 1'b1;
        tick();
        st_a = 1'b1; tick(); st_a = 1'b0;
        @(negedge clk);
        chk(!dn_a && !ex_a, "R10", "restart clears flags", 64'({dn_a, ex_a}), '0);
        drain_a();
        mon_a = 1'b0;

        // R9: exhaustion on the small instance, 39 candidates over 4 slots
        push_b(0, 39);
        mon_b = 1'b1;
        st_b = 1'b1; tick(); st_b = 1'b0;
        drain_b();
        chk(v_b == 4'b0111, "R9", "partial last cycle", 64'(v_b), 64'h7);
        chk(!ex_b, "R9", "not yet exhausted", 64'(ex_b), 64'd0);
        @(negedge clk);
        chk(ex_b && v_b == '0, "R9", "exhausted after last", 64'({ex_b, v_b}), 64'h10);
        chk(!dn_b, "R9", "no done on exhaustion", 64'(dn_b), 64'd0);
        mon_b = 1'b0;

        // R9: late hit after exhaustion still accepted
        tick();
        h_b = 4'b0100; hw_b[191:128] = 64'h2220; hl_b[11:8] = 4'd2;
        tick();
        h_b = '0;
        @(negedge clk);
        chk(dn_b && rw_b == 64'h2220, "R9", "late hit result", rw_b, 64'h2220);
        chk(rl_b == 4'd2, "R9", "late hit len", 64'(rl_b), 64'd2);

        finish_run();
    end

endmodule